// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the transmit framing pulse of a synchronous serial port. It runs on the bit clock that the port has already selected, from the receive clock or from a general-purpose pin wired as a transmit clock input. It counts bit periods in groups of one word, a fixed 16 bits. A second, programmable counter then counts words, so one frame lasts 16 × (rate + 1) bit periods.

A mode input sets the pulse shape. The pulse covers either the first bit period of each frame or the whole first word of each frame. A source selector then picks the framing signal the transmitter uses. It can be the receive-side frame signal, the internally generated pulse, or an external framing pin. When the internal pulse is chosen, the block drives the framing pin as an output carrying that pulse. Otherwise the pin is left as an input.

A new rate code is captured only at a frame boundary. The frame in progress therefore always runs to its full programmed length.

Top module: `fsync_gen`

## Requirements
- R1: While `rst` is high, `gen_fs_o` is low and both counters are cleared. The first clock cycle after `rst` falls is the first bit of a frame.
- R2: The rising edges of the internal pulse are spaced exactly 16 × (R + 1) bit clocks apart, where R is the captured rate code (0 to 15).
- R3: With `word_mode` = 0, `gen_fs_o` is high for exactly one bit clock, the first bit of each frame.
- R4: With `word_mode` = 1, `gen_fs_o` is high for the first 16 bit clocks of each frame and low for the rest of the frame.
- R5: The rate code is captured when `rst` is high and at the last bit of each frame. A change at any other time leaves the length of the current frame unchanged and applies from the next frame.
- R6: With `src_sel` = 00 or 01, `tx_fs_o` follows `rx_fs_i`.
- R7: With `src_sel` = 10, `tx_fs_o` equals the internal pulse, `pin_fs_oe` is 1 and `pin_fs_o` equals the internal pulse.
- R8: With `src_sel` = 11, `tx_fs_o` follows `pin_fs_i`.
- R9: With any `src_sel` other than 10, `pin_fs_oe` is 0 and `pin_fs_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | 4 | Frame-rate factor R; the frame lasts 16 × (R + 1) bits |
| word_mode | input | 1 | 0: one-bit pulse, 1: pulse lasting one word |
| src_sel | input | 2 | Framing source: 00/01 receive frame, 10 internal, 11 pin |
| rx_fs_i | input | 1 | Receive-side frame signal |
| pin_fs_i | input | 1 | Input value of the framing pin |
| pin_fs_o | output | 1 | Value driven onto the framing pin |
| pin_fs_oe | output | 1 | Output enable of the framing pin |
| gen_fs_o | output | 1 | Internally generated frame pulse |
| tx_fs_o | output | 1 | Framing signal used by the transmitter |

## Verification
The in-line assertions check on every cycle that:
- the bit counter wraps after 16 bits;
- the captured rate holds steady inside a frame;
- a one-bit pulse never lasts two cycles;
- the framing pin is quiet whenever its enable is low.

The rest needs the bench's scenarios:
- The exact frame spacing for small and maximum rate codes.
- A mid-frame rate change taking effect only after the boundary.
- The word-long pulse shape.
- Each source routing with toggling external framing inputs.

The bench's cycle-by-cycle reference model compares every output throughout.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int WORD_LEN = 16;
    localparam int RATE_W   = 4;

    typedef enum logic [1:0] {
        SRC_RX_A = 2'b00,
        SRC_RX_B = 2'b01,
        SRC_INT  = 2'b10,
        SRC_PIN  = 2'b11
    } fsg_src_e;

    typedef struct packed {
        logic rx_fs;
        logic gen_fs;
        logic pin_fs;
    } fsg_cand_t;

    typedef struct packed {
        logic tx_fs;
        logic pin_o;
        logic pin_oe;
    } fsg_route_t;

    function automatic logic drives_pin(input fsg_src_e s);
        return (s == SRC_INT);
    endfunction

endpackage

// File: rtl/fsg_bit_div.sv
module fsg_bit_div #(
    parameter int WLEN = fsg_pkg::WORD_LEN,
    localparam int CW  = $clog2(WLEN)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          first_bit,
    output logic          last_bit
);
    localparam logic [CW-1:0] LAST = CW'(WLEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign first_bit = (cnt_q == '0);
    assign last_bit  = (cnt_q == LAST);

    AST_BIT_WRAP: assert property (@(posedge clk) disable iff (rst)
        last_bit |=> first_bit); // R2

endmodule

// File: rtl/fsg_rate_div.sv
module fsg_rate_div #(
    parameter int RW = fsg_pkg::RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] rate_in,
    input  logic          word_end,
    output logic          first_word,
    output logic          frame_end
);
    logic [RW-1:0] rate_q;
    logic [RW-1:0] word_q;

    assign frame_end  = word_end && (word_q == rate_q);
    assign first_word = (word_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            rate_q <= rate_in;
        end else if (frame_end) begin
            word_q <= '0;
            rate_q <= rate_in;
        end else if (word_end) begin
            word_q <= word_q + 1'b1;
        end
    end

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(rate_q)); // R5

    AST_WORD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        word_end |=> (word_q <= rate_q)); // R2

endmodule

// File: rtl/fsg_src_mux.sv
module fsg_src_mux
    import fsg_pkg::*;
(
    input  logic       [1:0] sel,
    input  fsg_cand_t        cand,
    output fsg_route_t       route
);
    fsg_src_e src;
    assign src = fsg_src_e'(sel);

    always_comb begin
        route = '0;
        unique case (src)
            SRC_RX_A, SRC_RX_B: route.tx_fs = cand.rx_fs;
            SRC_INT:            route.tx_fs = cand.gen_fs;
            SRC_PIN:            route.tx_fs = cand.pin_fs;
            default:            route.tx_fs = 1'b0;
        endcase
        route.pin_oe = drives_pin(src);
        route.pin_o  = route.pin_oe & cand.gen_fs;
    end

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
    import fsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              word_mode,
    input  logic [1:0]        src_sel,
    input  logic              rx_fs_i,
    input  logic              pin_fs_i,
    output logic              pin_fs_o,
    output logic              pin_fs_oe,
    output logic              gen_fs_o,
    output logic              tx_fs_o
);
    logic       first_bit;
    logic       last_bit;
    logic       first_word;
    logic       frame_end;
    fsg_cand_t  cand;
    fsg_route_t route;

    fsg_bit_div #(.WLEN(WORD_LEN)) u_bit (
        .clk       (clk),
        .rst       (rst),
        .first_bit (first_bit),
        .last_bit  (last_bit)
    );

    fsg_rate_div #(.RW(RATE_W)) u_rate (
        .clk        (clk),
        .rst        (rst),
        .rate_in    (rate_code),
        .word_end   (last_bit),
        .first_word (first_word),
        .frame_end  (frame_end)
    );

    assign gen_fs_o = !rst && first_word && (word_mode || first_bit);

    assign cand.rx_fs  = rx_fs_i;
    assign cand.gen_fs = gen_fs_o;
    assign cand.pin_fs = pin_fs_i;

    fsg_src_mux u_mux (
        .sel   (src_sel),
        .cand  (cand),
        .route (route)
    );

    assign tx_fs_o   = route.tx_fs;
    assign pin_fs_o  = route.pin_o;
    assign pin_fs_oe = route.pin_oe;

    AST_BIT_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        (!word_mode && gen_fs_o) |=> (!gen_fs_o || word_mode)); // R3

    AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (gen_fs_o || (!word_mode && !first_bit))); // R2

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pin_fs_oe |-> !pin_fs_o); // R9

    AST_INT_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b10) |-> (tx_fs_o == gen_fs_o && pin_fs_o == gen_fs_o)); // R7

endmodule

// File: tb/fsync_gen_tb.sv
`timescale 1ns/100ps
module fsync_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rate_code = 4'd0;
    logic       word_mode = 1'b0;
    logic [1:0] src_sel = 2'b10;
    logic       rx_fs_i = 1'b0;
    logic       pin_fs_i = 1'b0;
    logic       pin_fs_o, pin_fs_oe, gen_fs_o, tx_fs_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fsync_gen u_dut (
        .clk(clk), .rst(rst), .rate_code(rate_code), .word_mode(word_mode),
        .src_sel(src_sel), .rx_fs_i(rx_fs_i), .pin_fs_i(pin_fs_i),
        .pin_fs_o(pin_fs_o), .pin_fs_oe(pin_fs_oe),
        .gen_fs_o(gen_fs_o), .tx_fs_o(tx_fs_o)
    );

    // behavioural reference: bit position, word position, captured rate
    int m_bit = 0;
    int m_word = 0;
    int m_rate = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_bit  <= 0;
            m_word <= 0;
            m_rate <= int'(rate_code);
        end else if (m_bit == 15) begin
            m_bit <= 0;
            if (m_word == m_rate) begin
                m_word <= 0;
                m_rate <= int'(rate_code);
            end else begin
                m_word <= m_word + 1;
            end
        end else begin
            m_bit <= m_bit + 1;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic eg, etx;
        if (!done) begin
            eg = !rst && (m_word == 0) && (word_mode || m_bit == 0);
            check(rst ? "R1" : (word_mode ? "R4" : "R3"), gen_fs_o, eg);
            case (src_sel)
                2'b00, 2'b01: begin etx = rx_fs_i;  check("R6", tx_fs_o, etx); end
                2'b10:        begin etx = eg;       check("R7", tx_fs_o, etx); end
                default:      begin etx = pin_fs_i; check("R8", tx_fs_o, etx); end
            endcase
            if (src_sel == 2'b10) begin
                check("R7", pin_fs_oe, 1'b1);
                check("R7", pin_fs_o, eg);
            end else begin
                check("R9", pin_fs_oe, 1'b0);
                check("R9", pin_fs_o, 1'b0);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic next_rise(output int t);
        logic p;
        p = gen_fs_o;
        forever begin
            @(negedge clk);
            if (gen_fs_o && !p) begin
                t = cyc;
                return;
            end
            p = gen_fs_o;
        end
    endtask

    task automatic do_reset(input logic [3:0] r);
        @(posedge clk); #1;
        rst = 1'b1;
        rate_code = r;
        step(3);
        rst = 1'b0;
    endtask

    initial begin
        int t0, t1, t2;
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2;
        // R1: reset and first frame
        step(3);
        @(negedge clk);
        check("R1", gen_fs_o, 1'b0);
        do_reset(4'd0);
        @(negedge clk);
        check("R1", gen_fs_o, 1'b1);

        // R2: rate 0 spacing
        next_rise(t0); next_rise(t1);
        check_int("R2", t1 - t0, 16);

        // R5: mid-frame change from 0 to 3
        step(5);
        rate_code = 4'd3;
        next_rise(t1);
        next_rise(t2);
        check_int("R5", t2 - t1, 64);
        rate_code = 4'd1;
        step(20);
        next_rise(t1);
        check_int("R5", t1 - t2, 64);
        next_rise(t2);
        check_int("R2", t2 - t1, 32);

        // R4: word-length pulse
        word_mode = 1'b1;
        step(100);
        rate_code = 4'd0;
        step(60);

        // R2: maximum rate
        word_mode = 1'b0;
        do_reset(4'd15);
        next_rise(t0);
        next_rise(t1);
        check_int("R2", t1 - t0, 256);
        word_mode = 1'b1;
        step(300);

        // R6 / R8 / R9: external sources with toggling inputs
        rate_code = 4'd2;
        for (int s = 0; s < 4; s++) begin
            src_sel = 2'(s);
            for (int k = 0; k < 40; k++) begin
                rx_fs_i  = k[0] ^ k[2];
                pin_fs_i = k[1];
                step(1);
            end
        end

        // reset in mid-frame
        src_sel = 2'b10;
        word_mode = 1'b0;
        step(7);
        do_reset(4'd1);
        step(120);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule